// File: doc/BRIEF.md
# Delayed Second-Sweep Start Controller

This block decides when a delayed second sweep (sweep B) may begin relative to a running main sweep (sweep A). It watches the main sweep gate, a pulse that marks the moment the main ramp reaches the chosen delay reference, and the B trigger event. From these it produces an arm output that enables the B trigger path and the B sweep, the B sweep gate itself, a digital select for which delay reference is in use, and a flag that brightens the display while both sweeps overlap.

Two start policies share the one delay point. In triggered mode the block arms at the delay point and then waits for the first B trigger event. In run mode the B sweep starts at the delay point itself and B triggers are not used. Only one B sweep may start per main sweep. When the main sweep ends, everything it armed is cleared. In alternate display mode the reference select advances by one after each completed main sweep.

All inputs are sampled on the rising clock edge, and all outputs except `intens` are registered.

Top module: `bsweep_start_ctl`

## Requirements
- R1: While `srst` is high at a clock edge, `b_arm`, `b_gate` and `ref_sel` are 0 after that edge, and `intens` is 0.
- R2: `b_arm` goes to 1 at the edge after `dly_evt` is sampled high while `a_gate` is high. A `dly_evt` sampled while `a_gate` is low leaves `b_arm` at 0.
- R3: When `mode_run`=0, `b_gate` goes to 1 at the edge after `b_trig` is sampled high while `b_arm` is 1. A `b_trig` sampled while `b_arm` is 0 has no effect.
- R4: When `mode_run`=1, `b_gate` goes to 1 at the same edge as `b_arm` (the edge after the qualifying `dly_evt`), and `b_trig` has no effect.
- R5: At most one B sweep starts per main sweep. After a B sweep has ended, `b_trig` is ignored until `a_gate` has been low for at least one edge.
- R6: `b_gate` returns to 0 at the edge after `b_end` is sampled high. `b_arm` and `b_gate` both return to 0 at the edge after `a_gate` is sampled low.
- R7: `intens` equals `a_gate` AND `b_gate` (with `INTENS_REG`=0, the default).
- R8: When `alt_en`=1, `ref_sel` advances by 1, modulo `REF_COUNT` (default 2, so it toggles 0/1), at the edge where `a_gate` is first sampled low after having been high. When `alt_en`=0 is sampled, `ref_sel` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| a_gate | input | 1 | Main sweep in progress, active high |
| dly_evt | input | 1 | Main ramp has reached the delay reference |
| b_trig | input | 1 | Qualifying B trigger event |
| mode_run | input | 1 | 1 = run mode, 0 = triggered mode |
| alt_en | input | 1 | Alternate display mode, which cycles the delay reference |
| b_end | input | 1 | B ramp has run to completion |
| b_arm | output | 1 | Delay reached: B trigger path and B sweep enabled |
| b_gate | output | 1 | B sweep in progress |
| ref_sel | output | REF_W | Delay reference in use |
| intens | output | 1 | Intensify zone: both sweeps active |

## Verification
The checker assumes that `mode_run` does not change while a main sweep is running. The run-mode start property compares the start with the mode from the previous cycle, and a mode change inside a sweep could break it on a correct design. It also assumes that reset is applied at the first edge. The bench changes the mode only while `a_gate` is low, and it drives all stimulus one time unit after a rising edge. It holds `dly_evt`, `b_trig` and `b_end` for a single cycle, so each counts as exactly one event.

// File: rtl/bss_pkg.sv
package bss_pkg;

    // State of the delay/arm tracker
    typedef struct packed {
        logic arm;
    } arm_st_t;

    // State of the B sweep gate
    typedef struct packed {
        logic gate;
        logic started;
    } gate_st_t;

endpackage

// File: rtl/bss_arm.sv
module bss_arm
    import bss_pkg::*;
(
    input  logic clk,
    input  logic srst,
    input  logic a_gate,
    input  logic dly_evt,
    input  logic b_trig,
    input  logic mode_run,
    input  logic started,
    output logic arm,
    output logic start
);
    arm_st_t st_d, st_q;
    logic    dly_hit;

    always_comb begin
        st_d    = st_q;
        dly_hit = a_gate & dly_evt & ~st_q.arm;
        // arm holds for the rest of the main sweep, dropped when it ends
        st_d.arm = a_gate & (st_q.arm | dly_evt);
        if (mode_run)
            start = a_gate & ~started & dly_hit;
        else
            start = a_gate & ~started & st_q.arm & b_trig;
        if (srst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign arm = st_q.arm;
endmodule

// File: rtl/bss_gate.sv
module bss_gate
    import bss_pkg::*;
(
    input  logic clk,
    input  logic srst,
    input  logic a_gate,
    input  logic start,
    input  logic b_end,
    output logic gate,
    output logic gate_nxt,
    output logic started
);
    gate_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.gate    = a_gate & (start | (st_q.gate & ~b_end));
        st_d.started = a_gate & (st_q.started | start);
        if (srst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign gate     = st_q.gate;
    assign gate_nxt = st_d.gate;
    assign started  = st_q.started;
endmodule

// File: rtl/bss_refsel.sv
module bss_refsel #(
    parameter int REF_COUNT = 2,
    localparam int REF_W = (REF_COUNT > 1) ? $clog2(REF_COUNT) : 1
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             a_gate,
    input  logic             alt_en,
    output logic [REF_W-1:0] ref_sel
);
    localparam logic [REF_W-1:0] LAST = REF_W'(REF_COUNT - 1);

    typedef struct packed {
        logic [REF_W-1:0] sel;
        logic             a_prev;
    } ref_st_t;

    ref_st_t st_d, st_q;
    logic    a_fall;

    always_comb begin
        st_d        = st_q;
        a_fall      = st_q.a_prev & ~a_gate;
        st_d.a_prev = a_gate;
        if (!alt_en)
            st_d.sel = '0;
        else if (a_fall)
            st_d.sel = (st_q.sel == LAST) ? '0 : st_q.sel + 1'b1;
        if (srst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ref_sel = st_q.sel;
endmodule

// File: rtl/bsweep_start_ctl.sv
module bsweep_start_ctl #(
    parameter int REF_COUNT  = 2,
    parameter bit INTENS_REG = 1'b0,
    localparam int REF_W = (REF_COUNT > 1) ? $clog2(REF_COUNT) : 1
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             a_gate,
    input  logic             dly_evt,
    input  logic             b_trig,
    input  logic             mode_run,
    input  logic             alt_en,
    input  logic             b_end,
    output logic             b_arm,
    output logic             b_gate,
    output logic [REF_W-1:0] ref_sel,
    output logic             intens
);
    logic start, started, gate_nxt;

    bss_arm u_arm (
        .clk(clk), .srst(srst), .a_gate(a_gate), .dly_evt(dly_evt),
        .b_trig(b_trig), .mode_run(mode_run), .started(started),
        .arm(b_arm), .start(start)
    );

    bss_gate u_gate (
        .clk(clk), .srst(srst), .a_gate(a_gate), .start(start),
        .b_end(b_end), .gate(b_gate), .gate_nxt(gate_nxt), .started(started)
    );

    bss_refsel #(.REF_COUNT(REF_COUNT)) u_ref (
        .clk(clk), .srst(srst), .a_gate(a_gate), .alt_en(alt_en),
        .ref_sel(ref_sel)
    );

    generate
        if (INTENS_REG) begin : g_int_reg
            logic int_d, int_q;
            always_comb int_d = srst ? 1'b0 : (a_gate & gate_nxt);
            always_ff @(posedge clk) int_q <= int_d;
            assign intens = int_q;
        end else begin : g_int_comb
            logic unused_nxt;
            assign unused_nxt = gate_nxt;
            assign intens = a_gate & b_gate;
        end
    endgenerate
endmodule

// File: rtl/bsweep_start_ctl_chk.sv
module bsweep_start_ctl_chk #(
    parameter int REF_COUNT  = 2,
    parameter bit INTENS_REG = 1'b0,
    localparam int REF_W = (REF_COUNT > 1) ? $clog2(REF_COUNT) : 1
) (
    input logic             clk,
    input logic             srst,
    input logic             a_gate,
    input logic             dly_evt,
    input logic             b_trig,
    input logic             mode_run,
    input logic             alt_en,
    input logic             b_end,
    input logic             b_arm,
    input logic             b_gate,
    input logic [REF_W-1:0] ref_sel,
    input logic             intens
);
    logic seen_q;
    always_ff @(posedge clk) begin
        if (srst) seen_q <= 1'b0;
        else      seen_q <= a_gate & (seen_q | b_gate);
    end

    // R2
    arm_cause_chk: assert property (@(posedge clk) disable iff (srst)
        $rose(b_arm) |-> $past(a_gate && dly_evt));

    // R3
    trig_start_chk: assert property (@(posedge clk) disable iff (srst)
        ($rose(b_gate) && !$past(mode_run)) |-> $past(b_arm && b_trig));

    // R4
    run_start_chk: assert property (@(posedge clk) disable iff (srst)
        ($rose(b_arm) && $past(mode_run)) |-> b_gate);

    // R5
    one_start_chk: assert property (@(posedge clk) disable iff (srst)
        $rose(b_gate) |-> !seen_q);

    // R6
    a_end_clear_chk: assert property (@(posedge clk) disable iff (srst)
        !a_gate |=> (!b_arm && !b_gate));

    // R6
    b_end_chk: assert property (@(posedge clk) disable iff (srst)
        b_end |=> !b_gate);

    // R8
    ref_idle_chk: assert property (@(posedge clk) disable iff (srst)
        !alt_en |=> (ref_sel == '0));

    // R7
    generate
        if (!INTENS_REG) begin : g_c
            intens_chk: assert property (@(posedge clk) disable iff (srst)
                intens == (a_gate && b_gate));
        end
    endgenerate

    logic unused_in;
    assign unused_in = b_end ^ dly_evt ^ b_trig;
endmodule

bind bsweep_start_ctl bsweep_start_ctl_chk #(.REF_COUNT(REF_COUNT), .INTENS_REG(INTENS_REG)) u_chk (
    .clk(clk), .srst(srst), .a_gate(a_gate), .dly_evt(dly_evt), .b_trig(b_trig),
    .mode_run(mode_run), .alt_en(alt_en), .b_end(b_end), .b_arm(b_arm),
    .b_gate(b_gate), .ref_sel(ref_sel), .intens(intens)
);

// File: tb/bsweep_start_ctl_test.sv
module bsweep_start_ctl_test;
    logic       clk = 1'b0;
    logic       srst, a_gate, dly_evt, b_trig, mode_run, alt_en, b_end;
    logic       b_arm, b_gate, intens;
    logic [0:0] ref_sel;
    int         n_run = 0, n_fail = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    bsweep_start_ctl uut (
        .clk(clk), .srst(srst), .a_gate(a_gate), .dly_evt(dly_evt),
        .b_trig(b_trig), .mode_run(mode_run), .alt_en(alt_en), .b_end(b_end),
        .b_arm(b_arm), .b_gate(b_gate), .ref_sel(ref_sel), .intens(intens)
    );

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic check(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        srst = 1; a_gate = 0; dly_evt = 0; b_trig = 0; mode_run = 0; alt_en = 0; b_end = 0;
        tick(); tick();
        check("R1", "b_arm", b_arm, 0);
        check("R1", "b_gate", b_gate, 0);
        check("R1", "ref_sel", ref_sel, 0);
        check("R1", "intens", intens, 0);
        srst = 0; tick();
    endtask

    task automatic t_trig_mode();
        mode_run = 0; a_gate = 1; tick();
        b_trig = 1; tick(); b_trig = 0;
        check("R3", "early trig ignored", b_gate, 0);
        dly_evt = 1; tick(); dly_evt = 0;
        check("R2", "arm after delay", b_arm, 1);
        check("R3", "no start without trig", b_gate, 0);
        tick();
        b_trig = 1; tick(); b_trig = 0;
        check("R3", "start on trig", b_gate, 1);
        check("R7", "intens overlap", intens, 1);
        b_end = 1; tick(); b_end = 0;
        check("R6", "b_end stops B", b_gate, 0);
        check("R7", "intens off", intens, 0);
        b_trig = 1; tick(); b_trig = 0;
        check("R5", "second trig ignored", b_gate, 0);
        a_gate = 0; tick();
        check("R6", "arm cleared", b_arm, 0);
    endtask

    task automatic t_run_mode();
        mode_run = 1; tick();
        a_gate = 1; tick();
        b_trig = 1; tick(); b_trig = 0;
        check("R4", "trig no effect", b_gate, 0);
        dly_evt = 1; tick(); dly_evt = 0;
        check("R4", "arm", b_arm, 1);
        check("R4", "start at delay", b_gate, 1);
        check("R7", "intens run", intens, 1);
        a_gate = 0; #1;
        check("R7", "intens a low", intens, 0);
        tick();
        check("R6", "A end stops B", b_gate, 0);
        check("R6", "A end clears arm", b_arm, 0);
        mode_run = 0; tick();
    endtask

    task automatic t_idle_delay();
        a_gate = 0; dly_evt = 1; tick(); dly_evt = 0;
        check("R2", "delay outside A", b_arm, 0);
    endtask

    task automatic t_ref();
        alt_en = 0; a_gate = 1; tick(); a_gate = 0; tick();
        check("R8", "no alt stays 0", ref_sel, 0);
        alt_en = 1; a_gate = 1; tick();
        check("R8", "no change mid sweep", ref_sel, 0);
        a_gate = 0; tick();
        check("R8", "advance", ref_sel, 1);
        a_gate = 1; tick(); a_gate = 0; tick();
        check("R8", "wrap", ref_sel, 0);
        a_gate = 1; tick(); a_gate = 0; tick();
        check("R8", "advance again", ref_sel, 1);
        alt_en = 0; tick();
        check("R8", "alt off clears", ref_sel, 0);
    endtask

    initial begin
        t_reset();
        t_trig_mode();
        t_run_mode();
        t_idle_delay();
        t_ref();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule